// File: doc/BRIEF.md
# Multi-Cycle Test Vector Packer

The block takes a stream of per-device-cycle pin vectors and folds 1, 2 or 4 consecutive device cycles into one wide tester word, so that a pattern occupies a half or a quarter of the vector storage it would need at one cycle per word. Each pin of an incoming vector carries a two-bit symbol: a plain data level, a return-to-zero pulse (low, high, low) or a return-to-one pulse (high, low, high). Every vector also carries a flag marking it as the final vector of a timing segment.

Two packing policies are selectable. In the padding policy, each segment is closed on a word boundary: a partly filled word is completed with padding slots that repeat the last real vector, and any vector that contains a pulse forces such a closure in front of it, because pulses are reduced to plain levels and need their own timing set. In the pulse-folding policy, pins declared as clocks have their pulses folded into one level each (a return-to-one pulse becomes 0, a return-to-zero pulse becomes 1), which is unambiguous because such a pin otherwise only carries its idle level; no segment is ever closed early and no padding is produced. Running counts of accepted vectors, emitted words and padding slots are exported for pattern-depth accounting.

Top module: `vector_packer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and cnt_in, cnt_out and cnt_pad are 0.
- R2: Pin p of in_sym occupies bits [2p+1:2p], coded 00 = level 0, 01 = level 1, 10 = return-to-zero pulse, 11 = return-to-one pulse; in padding policy, and for pins not set in cfg_clk_mask, a return-to-zero pulse packs as 0 and a return-to-one pulse as 1.
- R3: cfg_xsel 0, 1, 2 (and 3) gives 1, 2, 4 (and 4) device cycles per word; the earliest vector sits in slot 0 at out_word bits [NUM_PINS-1:0], slot k at bits [k*NUM_PINS +: NUM_PINS], out_pad bit k flags slot k, and slots at or above the factor are 0.
- R4: In padding policy (cfg_nopad = 0), a vector with in_last set closes its word: the remaining slots up to the factor repeat that vector with their out_pad bits set; segments of 1, 1, 1, 8 and 2 vectors yield 8 words with 3 padding slots at factor 2 and 6 words with 11 padding slots at factor 4.
- R5: In padding policy, a vector containing any pulse symbol that arrives while a word is partly filled is held off until that word is completed with padding slots repeating the previous vector; the pulse vector then starts the next word in slot 0.
- R6: In pulse-folding policy (cfg_nopad = 1), a pin set in cfg_clk_mask packs a return-to-one pulse as 0 and a return-to-zero pulse as 1, in_last has no effect, no padding slot is ever produced, and a partly filled word is held until it is full.
- R7: cnt_in counts accepted vectors, cnt_out counts accepted output words, and cnt_pad counts padding slots inserted.
- R8: While out_valid is 1 and out_ready is 0, out_word and out_pad stay unchanged and in_ready is 0; no vector is lost or reordered across a stall.
- R9: In pulse-folding policy, a stream of M times the factor vectors produces exactly M words, in order.
- R10: Slot 0 of an emitted word always holds a real vector (out_pad bit 0 is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_xsel | input | 2 | Packing factor select (0:1, 1:2, 2/3:4) |
| cfg_nopad | input | 1 | 1 selects pulse folding, 0 selects padding |
| cfg_clk_mask | input | NUM_PINS | Pins treated as clocks in pulse-folding policy |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Input vector accepted when high with in_valid |
| in_sym | input | 2*NUM_PINS | Two-bit symbol per pin |
| in_last | input | 1 | Vector ends its timing segment |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 4*NUM_PINS | Packed slots, earliest in slot 0 |
| out_pad | output | 4 | Per-slot padding flag |
| cnt_in | output | CNT_W | Accepted vector count |
| cnt_out | output | CNT_W | Emitted word count |
| cnt_pad | output | CNT_W | Inserted padding slot count |

## Verification
A wrong fill position shows up on the very next emitted word as a vector in the wrong slot or a word emitted one vector early or late, and every later word of the stream is then shifted, so the word count after a stream drifts from the expected figure. A wrong padding decision shows at once in out_pad and in cnt_pad when the segment closes, and the 1-1-1-8-2 segment mix pins the totals at both factors. A stale last-vector register shows in the content of the first padding slot that repeats it.

// File: rtl/vp_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, symbol codes and the factor decode for the
// vector packer. Assumes two drive edges per pulse and eight per tester cycle.
package vp_pkg;
    localparam int DRIVE_EDGES     = 8;
    localparam int EDGES_PER_PULSE = 2;
    localparam int MAX_SLOTS       = DRIVE_EDGES / EDGES_PER_PULSE;
    localparam int SLOT_W          = $clog2(MAX_SLOTS + 1);

    typedef enum logic [1:0] {
        SYM_LVL0  = 2'b00,
        SYM_LVL1  = 2'b01,
        SYM_PLS_RZ = 2'b10,
        SYM_PLS_RO = 2'b11
    } sym_e;

    // Decode the factor select into a slot count.
    function automatic logic [SLOT_W-1:0] factor_of(input logic [1:0] xsel);
        case (xsel)
            2'd0:    factor_of = SLOT_W'(1);
            2'd1:    factor_of = SLOT_W'(2);
            default: factor_of = SLOT_W'(MAX_SLOTS);
        endcase
    endfunction
endpackage

// File: rtl/vp_sym_map.sv
`timescale 1ns/1ps
// Symbol mapper: reduces each pin's two-bit symbol to one packed level and
// reports whether the vector holds any pulse. Purely combinational.
module vp_sym_map #(
    parameter int NUM_PINS = 4
) (
    input  logic [2*NUM_PINS-1:0] sym,
    input  logic [NUM_PINS-1:0]   clk_mask,
    input  logic                  fold_mode,
    output logic [NUM_PINS-1:0]   bits,
    output logic                  any_pulse
);
    logic [NUM_PINS-1:0] pulse;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic is_pulse;
        logic lvl;
        assign is_pulse = sym[2*p+1];
        assign lvl      = sym[2*p];
        // Folded clock pin inverts the pulse code; others keep the low bit.
        assign bits[p]  = (fold_mode && clk_mask[p]) ? (lvl ^ is_pulse) : lvl;
        assign pulse[p] = is_pulse;
    end

    assign any_pulse = |pulse;
endmodule

// File: rtl/vp_slot_acc.sv
`timescale 1ns/1ps
// Slot accumulator: fills slots of one output word, inserts padding on
// segment closure, and presents the word with valid/ready. Assumes factor
// and policy only change while no partial word is held.
module vp_slot_acc
    import vp_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOT_W-1:0]             factor,
    input  logic                          pad_mode,
    input  logic [NUM_PINS-1:0]           vec_bits,
    input  logic                          vec_pulse,
    input  logic                          vec_last,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [MAX_SLOTS*NUM_PINS-1:0] out_word,
    output logic [MAX_SLOTS-1:0]          out_pad,
    output logic                          acc_fire,
    output logic                          out_fire,
    output logic [SLOT_W-1:0]             pad_add
);
    logic [SLOT_W-1:0]   fill_q, fill_nxt, base, nxt_pos;
    logic [NUM_PINS-1:0] last_q;
    logic                full, pre_pad, do_pre, post_pad;

    // Handshake and closure decisions for this cycle.
    always_comb begin
        full     = (fill_q == factor);
        out_fire = full && out_ready;
        base     = out_fire ? '0 : fill_q;
        pre_pad  = pad_mode && vec_pulse && !full && (fill_q != '0);
        in_ready = (!full || out_ready) && !pre_pad;
        acc_fire = in_valid && in_ready;
        do_pre   = in_valid && pre_pad;
        nxt_pos  = base + SLOT_W'(1);
        post_pad = acc_fire && pad_mode && vec_last && (nxt_pos != factor);
    end

    // Next fill level and number of padding slots added.
    always_comb begin
        fill_nxt = fill_q;
        pad_add  = '0;
        if (acc_fire) begin
            fill_nxt = post_pad ? factor : nxt_pos;
            if (post_pad) pad_add = factor - nxt_pos;
        end else if (do_pre) begin
            fill_nxt = factor;
            pad_add  = factor - fill_q;
        end else if (out_fire) begin
            fill_nxt = '0;
        end
    end

    // Fill level and last real vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            last_q <= '0;
        end else begin
            fill_q <= fill_nxt;
            if (acc_fire) last_q <= vec_bits;
        end
    end

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
        localparam logic [SLOT_W-1:0] IDX = SLOT_W'(g);
        logic [NUM_PINS-1:0] data_q;
        logic                pad_q;
        logic                wr_real, wr_post, wr_pre;

        // Write enables for this slot.
        always_comb begin
            wr_real = acc_fire && (base == IDX);
            wr_post = post_pad && (IDX > base) && (IDX < factor);
            wr_pre  = do_pre && (IDX >= fill_q) && (IDX < factor);
        end

        // Slot content and padding flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                pad_q  <= 1'b0;
            end else if (wr_real) begin
                data_q <= vec_bits;
                pad_q  <= 1'b0;
            end else if (wr_post) begin
                data_q <= vec_bits;
                pad_q  <= 1'b1;
            end else if (wr_pre) begin
                data_q <= last_q;
                pad_q  <= 1'b1;
            end else if (out_fire) begin
                data_q <= '0;
                pad_q  <= 1'b0;
            end
        end

        assign out_word[g*NUM_PINS +: NUM_PINS] = data_q;
        assign out_pad[g] = pad_q;
    end

    assign out_valid = full;
endmodule

// File: rtl/vp_stat_cnt.sv
`timescale 1ns/1ps
// Statistics counter: adds a small increment each cycle, wraps at CNT_W bits.
module vp_stat_cnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    // Accumulate the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + CNT_W'(inc);
    end
endmodule

// File: rtl/vector_packer.sv
`timescale 1ns/1ps
// Vector packer top: maps pin symbols, packs 1/2/4 device cycles per
// tester word under the padding or pulse-folding policy, and counts traffic.
// Assumes configuration inputs change only while no partial word is held.
module vector_packer
    import vp_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int CNT_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    cfg_xsel,
    input  logic                          cfg_nopad,
    input  logic [NUM_PINS-1:0]           cfg_clk_mask,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [2*NUM_PINS-1:0]         in_sym,
    input  logic                          in_last,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [MAX_SLOTS*NUM_PINS-1:0] out_word,
    output logic [MAX_SLOTS-1:0]          out_pad,
    output logic [CNT_W-1:0]              cnt_in,
    output logic [CNT_W-1:0]              cnt_out,
    output logic [CNT_W-1:0]              cnt_pad
);
    logic [NUM_PINS-1:0] vec_bits;
    logic                vec_pulse, acc_fire, out_fire;
    logic [SLOT_W-1:0]   pad_add, factor;

    assign factor = factor_of(cfg_xsel);

    vp_sym_map #(.NUM_PINS(NUM_PINS)) u_map (
        .sym       (in_sym),
        .clk_mask  (cfg_clk_mask),
        .fold_mode (cfg_nopad),
        .bits      (vec_bits),
        .any_pulse (vec_pulse)
    );

    vp_slot_acc #(.NUM_PINS(NUM_PINS)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .factor    (factor),
        .pad_mode  (!cfg_nopad),
        .vec_bits  (vec_bits),
        .vec_pulse (vec_pulse),
        .vec_last  (in_last),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_pad   (out_pad),
        .acc_fire  (acc_fire),
        .out_fire  (out_fire),
        .pad_add   (pad_add)
    );

    vp_stat_cnt #(.CNT_W(CNT_W), .INC_W(1)) u_cnt_in (
        .clk(clk), .rst_n(rst_n), .inc(acc_fire), .count(cnt_in)
    );
    vp_stat_cnt #(.CNT_W(CNT_W), .INC_W(1)) u_cnt_out (
        .clk(clk), .rst_n(rst_n), .inc(out_fire), .count(cnt_out)
    );
    vp_stat_cnt #(.CNT_W(CNT_W), .INC_W(SLOT_W)) u_cnt_pad (
        .clk(clk), .rst_n(rst_n), .inc(pad_add), .count(cnt_pad)
    );
endmodule

// File: rtl/vector_packer_chk.sv
`timescale 1ns/1ps
// Checker for the vector packer, attached through bind; observes ports only.
module vector_packer_chk #(
    parameter int NUM_PINS = 4,
    parameter int CNT_W    = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            cfg_xsel,
    input logic                  cfg_nopad,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [4*NUM_PINS-1:0] out_word,
    input logic [3:0]            out_pad,
    input logic [CNT_W-1:0]      cnt_in,
    input logic [CNT_W-1:0]      cnt_out,
    input logic [CNT_W-1:0]      cnt_pad
);
    a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_pad));

    a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r7_in_count: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> cnt_in == $past(cnt_in) + CNT_W'(1));

    a_r7_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(cnt_in));

    a_r7_out_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> cnt_out == $past(cnt_out) + CNT_W'(1));

    a_r6_no_padding: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_nopad |=> $stable(cnt_pad));

    a_r10_slot0_real: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_pad[0]);

    a_r3_x1_unpadded: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cfg_xsel == 2'd0 |-> out_pad == 4'b0000);
endmodule

bind vector_packer vector_packer_chk #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_xsel  (cfg_xsel),
    .cfg_nopad (cfg_nopad),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_pad   (out_pad),
    .cnt_in    (cnt_in),
    .cnt_out   (cnt_out),
    .cnt_pad   (cnt_pad)
);

// File: tb/vector_packer_tb.sv
`timescale 1ns/1ps
module vector_packer_tb;
    localparam int CLK_P = 10;
    localparam int NP    = 4;
    localparam int CW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_xsel = 2'd0;
    logic          cfg_nopad = 1'b0;
    logic [NP-1:0] cfg_clk_mask = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2*NP-1:0] in_sym = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [4*NP-1:0] out_word;
    logic [3:0]    out_pad;
    logic [CW-1:0] cnt_in, cnt_out, cnt_pad;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [4*NP-1:0] got_w [256];
    logic [3:0]      got_p [256];
    int              n_got = 0;

    vector_packer #(.NUM_PINS(NP), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_xsel(cfg_xsel), .cfg_nopad(cfg_nopad),
        .cfg_clk_mask(cfg_clk_mask), .in_valid(in_valid), .in_ready(in_ready),
        .in_sym(in_sym), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .out_pad(out_pad),
        .cnt_in(cnt_in), .cnt_out(cnt_out), .cnt_pad(cnt_pad)
    );

    always #(CLK_P/2) clk = ~clk;

    // Word collector: samples a quarter period before each rising edge.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n && out_valid && out_ready && n_got < 256) begin
            got_w[n_got] = out_word;
            got_p[n_got] = out_pad;
            n_got++;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*NP-1:0] lvl_sym(input logic [NP-1:0] d);
        logic [2*NP-1:0] s;
        for (int p = 0; p < NP; p++) s[2*p +: 2] = {1'b0, d[p]};
        return s;
    endfunction

    task automatic settle();
        @(negedge clk);
        #(CLK_P/4);
    endtask

    task automatic send(input logic [2*NP-1:0] s, input logic l);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_sym = s; in_last = l;
        do begin
            #(CLK_P/4);
            ok = in_ready;
            if (!ok) @(negedge clk);
        end while (!ok);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        settle();
        check("R1 out_valid", out_valid, 0);
        check("R1 in_ready", in_ready, 1);
        check("R1 counters", {cnt_in, cnt_out} | cnt_pad, 0);
    endtask

    task automatic t_x1_map();
        int g0 = n_got;
        logic [CW-1:0] p0 = cnt_pad;
        cfg_xsel = 2'd0; cfg_nopad = 1'b0;
        // pin3 RO, pin2 RZ, pin1 level1, pin0 level0 -> 1010
        send({2'b11, 2'b10, 2'b01, 2'b00}, 1'b0);
        send(lvl_sym(4'hF), 1'b1);
        idle(3); settle();
        check("R2 pulse levels", got_w[g0], 16'h000A);
        check("R3 x1 upper slots zero", got_w[g0+1], 16'h000F);
        check("R3 x1 word count", n_got - g0, 2);
        check("R3 x1 no pad", cnt_pad - p0, 0);
    endtask

    task automatic t_segments(input logic [1:0] xs, input int exp_words, input int exp_pad);
        int g0 = n_got;
        logic [CW-1:0] p0 = cnt_pad, o0 = cnt_out;
        int lens [5] = '{1, 1, 1, 8, 2};
        int v = 1;
        cfg_xsel = xs; cfg_nopad = 1'b0;
        for (int s = 0; s < 5; s++)
            for (int i = 0; i < lens[s]; i++) begin
                send(lvl_sym(NP'(v)), i == lens[s] - 1);
                v++;
            end
        idle(3); settle();
        check("R4 word count", cnt_out - o0, exp_words);
        check("R4 pad count", cnt_pad - p0, exp_pad);
        if (xs == 2'd2) begin
            check("R4 first word repeats", got_w[g0], 16'h1111);
            check("R4 first pad flags", got_p[g0], 4'b1110);
            check("R4 last word", got_w[g0+5], 16'hDDDC);
            check("R4 last pad flags", got_p[g0+5], 4'b1100);
        end else begin
            check("R4 x2 first word", got_w[g0], 16'h0011);
            check("R4 x2 first pad", got_p[g0], 4'b0010);
        end
    endtask

    task automatic t_break();
        int g0 = n_got;
        logic [CW-1:0] p0 = cnt_pad;
        cfg_xsel = 2'd2; cfg_nopad = 1'b0;
        send(lvl_sym(4'h3), 1'b0);
        send(lvl_sym(4'h5), 1'b0);
        send({2'b00, 2'b00, 2'b01, 2'b10}, 1'b0); // RZ on pin0 -> 0010
        send(lvl_sym(4'h9), 1'b1);
        idle(3); settle();
        check("R5 closed word", got_w[g0], 16'h5553);
        check("R5 closed pad", got_p[g0], 4'b1100);
        check("R5 pulse starts word", got_w[g0+1], 16'h9992);
        check("R5 pad total", cnt_pad - p0, 4);
    endtask

    task automatic t_fold();
        int g0 = n_got;
        logic [CW-1:0] p0 = cnt_pad;
        cfg_xsel = 2'd1; cfg_nopad = 1'b1; cfg_clk_mask = 4'b0011;
        send({2'b01, 2'b11, 2'b10, 2'b11}, 1'b1); // -> 1110
        idle(2); settle();
        check("R6 last ignored, held", out_valid, 0);
        send({2'b00, 2'b10, 2'b11, 2'b10}, 1'b0); // -> 0001
        idle(3); settle();
        check("R6 folded word", got_w[g0], 16'h001E);
        check("R6 no pad flags", got_p[g0], 4'b0000);
        check("R6 no pad count", cnt_pad - p0, 0);
        cfg_clk_mask = '0;
    endtask

    task automatic t_ratio();
        int g0 = n_got;
        logic [CW-1:0] o0 = cnt_out, i0 = cnt_in;
        cfg_xsel = 2'd2; cfg_nopad = 1'b1;
        for (int i = 0; i < 40; i++) send(lvl_sym(NP'(i)), i % 7 == 3);
        idle(3); settle();
        check("R9 words", cnt_out - o0, 10);
        check("R7 inputs", cnt_in - i0, 40);
        for (int j = 0; j < 10; j++)
            check("R9 word content", got_w[g0+j],
                  {NP'(4*j+3), NP'(4*j+2), NP'(4*j+1), NP'(4*j)});
    endtask

    task automatic t_stall();
        int g0 = n_got;
        logic [4*NP-1:0] w0;
        cfg_xsel = 2'd0; cfg_nopad = 1'b0;
        @(negedge clk); out_ready = 1'b0;
        send(lvl_sym(4'h5), 1'b0);
        @(negedge clk); in_valid = 1'b0;
        #(CLK_P/4);
        check("R8 valid while stalled", out_valid, 1);
        check("R8 input blocked", in_ready, 0);
        w0 = out_word;
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        check("R8 word stable", out_word, w0);
        @(negedge clk); out_ready = 1'b1;
        send(lvl_sym(4'h6), 1'b0);
        idle(3); settle();
        check("R8 order first", got_w[g0], 16'h0005);
        check("R8 order second", got_w[g0+1], 16'h0006);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_x1_map();
        t_segments(2'd1, 8, 3);
        t_segments(2'd2, 6, 11);
        t_break();
        t_fold();
        t_ratio();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule